// File: doc/BRIEF.md
# Dual Lookup-Table Logic Cell

This block is one programmable logic cell of the kind that tiles a lookup-table fabric. It holds two independent 4-input function generators, F and G. Each is a 16-entry, 1-bit truth table addressed by its own four inputs. A combining multiplexer forms a third function, H, from F and G under a separate select input, so H can depend on up to nine inputs. Four independently configured source selectors pick F, G, H or a constant zero for two combinational outputs and for the D inputs of two flip-flops. The flip-flops drive two registered outputs.

All table contents and selector codes sit in a 40-bit configuration register. The register is loaded serially, one bit per clock, while the load enable is high. Its far end feeds the next cell in a chain. The cell has two modes, chosen each cycle by the load enable: MODE_RUN, entered when `cfg_en` is low, and MODE_LOAD, entered when `cfg_en` is high. In MODE_LOAD the combinational outputs are held at zero and the flip-flops keep their values, so a half-loaded configuration never reaches the outputs or the registers. Dropping `cfg_en` is the transition MODE_LOAD to MODE_RUN, and raising it is the transition MODE_RUN to MODE_LOAD.

Top module: `lut_pair_cell`

## Requirements
- R1: In MODE_RUN, with source F selected, the output equals the F table entry whose index is the value of `f_in`. Entry 0 is the first configuration bit shifted in.
- R2: In MODE_RUN, with source G selected, the output equals the G table entry whose index is the value of `g_in`. The G table occupies configuration stream positions 16 to 31.
- R3: Source H equals F when `h_sel` is 1 and equals G when `h_sel` is 0.
- R4: A 2-bit selector code picks the source: 0 gives F, 1 gives G, 2 gives H and 3 gives constant 0. The four selectors (X, Y, XQ-D, YQ-D) act independently.
- R5: On a rising clock edge with `ce` high, `cfg_en` low and `rst` low, `xq_out` and `yq_out` take the values of their selected sources. The new values are visible after that edge.
- R6: With `ce` low, the flip-flops keep their values whatever the data inputs do.
- R7: A synchronous reset clears both flip-flops to 0 on the next rising edge. The configuration, and with it the combinational function, is left unchanged.
- R8: The configuration stream order is: F entries 0 to 15, then G entries 0 to 15, then the X selector, the Y selector, the XQ-D selector and the YQ-D selector. Each selector is sent low bit first. The register takes one bit per rising edge only while `cfg_en` is high, and it keeps its content while `cfg_en` is low.
- R9: `cfg_out` shows the oldest stored bit. During a reload it presents the previous configuration in stream order, one bit per load cycle.
- R10: While `cfg_en` is high, `x_out` and `y_out` are 0 and both flip-flops hold their values, even when `ce` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the two flip-flops |
| cfg_en | input | 1 | Configuration shift enable; selects MODE_LOAD |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out to the next cell |
| ce | input | 1 | Flip-flop clock enable |
| f_in | input | LUT_K | Address inputs of function generator F |
| g_in | input | LUT_K | Address inputs of function generator G |
| h_sel | input | 1 | Combining select: 1 picks F, 0 picks G |
| x_out | output | 1 | Combinational output X |
| y_out | output | 1 | Combinational output Y |
| xq_out | output | 1 | Registered output XQ |
| yq_out | output | 1 | Registered output YQ |

## Verification
A table bit stored at the wrong position shows up on `x_out` or `y_out` in the same cycle that the inputs address that entry. For that reason every 9-bit input combination is swept under each selector code. A wrong flip-flop source or a wrong enable shows up on `xq_out` or `yq_out` one edge after the inputs are applied. A fault in the shift chain's order or length only appears at `cfg_out` during the next reload, up to 40 cycles later, so every reload compares the bits leaving the cell with the configuration loaded before it.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int SEL_W     = 2;
    localparam int NUM_SINKS = 4;

    // Sink order inside the selector field of the configuration stream
    localparam int SINK_X  = 0;
    localparam int SINK_Y  = 1;
    localparam int SINK_XQ = 2;
    localparam int SINK_YQ = 3;

    typedef enum logic [SEL_W-1:0] {
        SRC_F    = 2'b00,
        SRC_G    = 2'b01,
        SRC_H    = 2'b10,
        SRC_ZERO = 2'b11
    } src_sel_e;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_LOAD = 1'b1
    } cell_mode_e;

endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             sin,
    output logic [WIDTH-1:0] bits,
    output logic             sout
);

    logic [WIDTH-1:0] store;

    // New bits enter at the top, so the first bit sent ends at index 0
    always_ff @(posedge clk) begin
        if (shift_en) begin
            store <= {sin, store[WIDTH-1:1]};
        end
    end

    assign bits = store;
    assign sout = store[0];

    // R8: content frozen outside load mode
    a_r8_cfg_frozen: assert property (@(posedge clk)
        !shift_en |=> $stable(store));

endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      addr,
    output logic              value
);

    localparam int DEPTH = 1 << K;

    logic [DEPTH-1:0] row;

    always_comb begin
        row   = table_bits;
        value = row[addr];
    end

endmodule

// File: rtl/lcell_src_mux.sv
module lcell_src_mux
    import lcell_pkg::*;
(
    input  src_sel_e sel,
    input  logic     f_val,
    input  logic     g_val,
    input  logic     h_val,
    output logic     o
);

    always_comb begin
        unique case (sel)
            SRC_F:    o = f_val;
            SRC_G:    o = g_val;
            SRC_H:    o = h_val;
            SRC_ZERO: o = 1'b0;
            default:  o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (upd) begin
            q <= d;
        end
    end

    // R7: synchronous clear
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> !q);

    // R6: no update without enable
    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(q));

endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell
    import lcell_pkg::*;
#(
    parameter int LUT_K = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic             ce,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_sel,
    output logic             x_out,
    output logic             y_out,
    output logic             xq_out,
    output logic             yq_out
);

    localparam int LUT_D  = 1 << LUT_K;
    localparam int F_LO   = 0;
    localparam int G_LO   = LUT_D;
    localparam int SEL_LO = 2 * LUT_D;
    localparam int CFG_W  = SEL_LO + NUM_SINKS * SEL_W;

    logic [CFG_W-1:0]     cfg_bits;
    logic                 f_val;
    logic                 g_val;
    logic                 h_val;
    src_sel_e             sink_sel [NUM_SINKS];
    logic [NUM_SINKS-1:0] sink_val;
    cell_mode_e           mode;
    logic                 ff_upd;
    logic [1:0]           ff_q;

    lcell_cfg_chain #(.WIDTH(CFG_W)) i_chain (
        .clk      (clk),
        .shift_en (cfg_en),
        .sin      (cfg_in),
        .bits     (cfg_bits),
        .sout     (cfg_out)
    );

    lcell_lut #(.K(LUT_K)) i_lut_f (
        .table_bits (cfg_bits[F_LO +: LUT_D]),
        .addr       (f_in),
        .value      (f_val)
    );

    lcell_lut #(.K(LUT_K)) i_lut_g (
        .table_bits (cfg_bits[G_LO +: LUT_D]),
        .addr       (g_in),
        .value      (g_val)
    );

    assign h_val = h_sel ? f_val : g_val;

    for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
        assign sink_sel[s] = src_sel_e'(cfg_bits[SEL_LO + s*SEL_W +: SEL_W]);

        lcell_src_mux i_mux (
            .sel   (sink_sel[s]),
            .f_val (f_val),
            .g_val (g_val),
            .h_val (h_val),
            .o     (sink_val[s])
        );
    end

    assign mode = cfg_en ? MODE_LOAD : MODE_RUN;

    always_comb begin
        unique case (mode)
            MODE_RUN: begin
                x_out  = sink_val[SINK_X];
                y_out  = sink_val[SINK_Y];
                ff_upd = ce;
            end
            MODE_LOAD: begin
                x_out  = 1'b0;
                y_out  = 1'b0;
                ff_upd = 1'b0;
            end
            default: begin
                x_out  = 1'b0;
                y_out  = 1'b0;
                ff_upd = 1'b0;
            end
        endcase
    end

    for (genvar r = 0; r < 2; r++) begin : g_reg
        lcell_ff i_ff (
            .clk (clk),
            .rst (rst),
            .upd (ff_upd),
            .d   (sink_val[SINK_XQ + r]),
            .q   (ff_q[r])
        );
    end

    assign xq_out = ff_q[0];
    assign yq_out = ff_q[1];

    // R10: loading never disturbs the registers
    a_r10_load_holds: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable({xq_out, yq_out}));

    // R5: enabled edge captures the selected sources
    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        (ce && !cfg_en) |=> (xq_out == $past(sink_val[SINK_XQ]))
                            && (yq_out == $past(sink_val[SINK_YQ])));

endmodule

// File: tb/test_lut_pair_cell.sv
`timescale 1ns/1ps
module test_lut_pair_cell;

    logic       clk = 1'b0;
    logic       rst, cfg_en, cfg_in, cfg_out, ce, h_sel;
    logic [3:0] f_in, g_in;
    logic       x_out, y_out, xq_out, yq_out;

    int checks = 0;
    int errors = 0;
    logic [39:0] cur_cfg;
    bit          have_cfg = 1'b0;

    always #2.5 clk = ~clk;

    lut_pair_cell i_lut_pair_cell (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
        .ce(ce), .f_in(f_in), .g_in(g_in), .h_sel(h_sel),
        .x_out(x_out), .y_out(y_out), .xq_out(xq_out), .yq_out(yq_out)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic ref_src(logic [1:0] s, logic f, logic g, logic h);
        case (s)
            2'd0: return f;
            2'd1: return g;
            2'd2: return h;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] s);
        case (s)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Stream position k = vector bit k (R8)
    function automatic logic [39:0] mk_cfg(logic [15:0] ft, logic [15:0] gt, logic [1:0] xs,
                                           logic [1:0] ys, logic [1:0] xqs, logic [1:0] yqs);
        return {yqs, xqs, ys, xs, gt, ft};
    endfunction

    task automatic load(logic [39:0] v);
        logic hx, hy;
        hx = 1'b0;
        hy = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_in = v[k];
            #1;
            if (k == 0) begin
                hx = xq_out;
                hy = yq_out;
            end
            chk("R10", "x_out in load", x_out, 0);
            chk("R10", "y_out in load", y_out, 0);
            chk("R10", "regs held in load", {xq_out, yq_out}, {hx, hy});
            if (have_cfg) chk("R9", "cfg_out order", cfg_out, cur_cfg[k]);
        end
        @(negedge clk);
        cfg_en = 1'b0;
        #1;
        chk("R10", "regs held after load", {xq_out, yq_out}, {hx, hy});
        cur_cfg  = v;
        have_cfg = 1'b1;
    endtask

    task automatic sweep(logic [15:0] ft, logic [15:0] gt, logic [1:0] xs, logic [1:0] ys,
                         logic [1:0] xqs, logic [1:0] yqs);
        logic fv, gv, hv;
        load(mk_cfg(ft, gt, xs, ys, xqs, yqs));
        ce = 1'b1;
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            f_in  = a[3:0];
            g_in  = a[7:4];
            h_sel = a[8];
            #1;
            fv = ft[f_in];
            gv = gt[g_in];
            hv = h_sel ? fv : gv;
            chk(tag_of(xs), "x_out", x_out, ref_src(xs, fv, gv, hv));
            chk(tag_of(ys), "y_out", y_out, ref_src(ys, fv, gv, hv));
            @(posedge clk);
            #1;
            chk("R5", "xq_out", xq_out, ref_src(xqs, fv, gv, hv));
            chk("R5", "yq_out", yq_out, ref_src(yqs, fv, gv, hv));
        end
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic hx, hy;
        rst = 1'b1; cfg_en = 1'b0; cfg_in = 1'b0; ce = 1'b0;
        f_in = '0; g_in = '0; h_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "regs after reset", {xq_out, yq_out}, 2'b00);
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive input sweeps, every selector code on every sink (R1..R5)
        sweep(16'h8000, 16'h6996, 2'd0, 2'd1, 2'd2, 2'd3);
        sweep(16'hA5C3, 16'h1E7F, 2'd1, 2'd2, 2'd3, 2'd0);
        sweep(16'h6996, 16'h0001, 2'd2, 2'd3, 2'd0, 2'd1);
        sweep(16'h3C5A, 16'hF00F, 2'd3, 2'd0, 2'd1, 2'd2);
        sweep(16'h0020, 16'h8421, 2'd2, 2'd2, 2'd2, 2'd2);

        // R6: ce low holds registers while the sources change
        @(negedge clk);
        ce = 1'b0;
        #1;
        hx = xq_out;
        hy = yq_out;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = a[3:0]; g_in = ~a[3:0]; h_sel = a[0];
            @(posedge clk);
            #1;
            chk("R6", "regs held ce low", {xq_out, yq_out}, {hx, hy});
        end

        // R8: cfg_in ignored while cfg_en low; single-bit table placement
        load(mk_cfg(16'h0020, 16'h0000, 2'd0, 2'd3, 2'd0, 2'd0));
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            cfg_in = ~cfg_in;
        end
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            f_in = a[3:0];
            #1;
            chk("R8", "F entry 5 only", x_out, (a == 5) ? 1 : 0);
        end

        // R5/R7: registers set, then reset, config retained
        load(mk_cfg(16'hFFFF, 16'hFFFF, 2'd0, 2'd1, 2'd0, 2'd1));
        @(negedge clk);
        ce = 1'b1;
        @(posedge clk);
        #1;
        chk("R5", "regs set to ones", {xq_out, yq_out}, 2'b11);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R7", "regs cleared by reset", {xq_out, yq_out}, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R7", "config kept over reset", {x_out, y_out}, 2'b11);
        @(posedge clk);
        #1;
        chk("R5", "regs reload after reset", {xq_out, yq_out}, 2'b11);

        // R10 with ce high, R9 on the following reload
        load(mk_cfg(16'h0000, 16'h0000, 2'd3, 2'd3, 2'd3, 2'd3));
        @(posedge clk);
        #1;
        chk("R4", "zero sources reach regs", {xq_out, yq_out}, 2'b00);
        load(mk_cfg(16'h1234, 16'h5678, 2'd0, 2'd1, 2'd2, 2'd3));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule